// File: doc/BRIEF.md
# Dual-Task Timing Reference Code Generator

This block produces the start-of-active-video and end-of-active-video timing reference codes for a scaler output stream shared by two processing tasks. Each time a task is activated the block makes it the current task, flips that task's odd/even activation flag and captures the task's configuration: whether bit 6 of the code carries the live input field ID or the task's activation flag, and whether bit 7 is inverted to mark the task. A downstream device can then tell the two tasks apart and rebuild interlaced output at a reduced frame rate.

A code request strobe, qualified by a start/end select and the vertical blanking flag, yields the code's final status byte one clock later. The full four-byte reference sequence (FF, 00, 00, status) is emitted on a byte stream starting in that same cycle. A general-purpose output pin can show either the bit-6 value or the bit-7 task marker.

Top module: `vid_timing_code_gen`

## Requirements
- R1: Each accepted activation of a task inverts that task's toggle flag (`task_toggle`, bit index = task index, 0 = even count, 1 = odd count). A task that is not activated keeps its flag. Changes of `field_id_in` never alter any flag.
- R2: When several bits of `task_act` are set in one cycle, the highest index wins (index 1 = task B over index 0 = task A). Only the winner's flag changes, and `active_task` becomes the winner's index on the next cycle.
- R3: Bit 6 of the status byte equals `field_id_in` when the active task's captured field-ID select is 0. It equals the active task's toggle flag when that select is 1.
- R4: Bit 7 of the status byte is 1 when the active task's captured marker bit is 0, and 0 when it is 1.
- R5: Bit 5 of the status byte is `vblank_in` and bit 4 is `code_is_eav` (0 start, 1 end). Bits 3..0 are (V^H), (F^H), (F^V), (F^V^H), where F, V and H are bits 6, 5 and 4.
- R6: `cfg_fid_sel` and `cfg_mark_inv` are sampled only in the cycle a task wins activation. Later changes have no effect until the next activation.
- R7: An accepted `code_req` sets `xy_valid` with the status byte in `xy_byte` on the next cycle. On four consecutive cycles starting then, `trs_valid` is 1 and `trs_byte` carries FF, 00, 00, then the status byte. Otherwise `trs_valid` and `trs_byte` are 0.
- R8: A `code_req` arriving while a four-byte sequence is still in progress is ignored. The sequence in flight completes unchanged and `xy_valid` does not pulse again.
- R9: `gp_pin` is registered. One cycle after the inputs, it shows the bit-6 value when `pin_sel` is 0 and the bit-7 marker when `pin_sel` is 1.
- R10: A `soft_rst` cycle clears both toggle flags, sets `active_task` to 0 and restores the default configuration (field ID on bit 6, bit 7 forced to 1). It overrides an activation in the same cycle.
- R11: After `rst_n` is deasserted, the following outputs are 0: `task_toggle`, `active_task`, `xy_valid`, `xy_byte`, `trs_valid`, `trs_byte` and `gp_pin`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous task-state reset |
| task_act | input | N_TASKS | Activation pulse per task |
| cfg_fid_sel | input | N_TASKS | Per task: bit 6 carries toggle flag (1) or field ID (0) |
| cfg_mark_inv | input | N_TASKS | Per task: invert bit 7 |
| field_id_in | input | 1 | Input field ID |
| vblank_in | input | 1 | Vertical blanking flag |
| code_is_eav | input | 1 | 0 start-of-active code, 1 end-of-active code |
| code_req | input | 1 | Code request strobe |
| pin_sel | input | 1 | Pin shows bit 6 (0) or task marker (1) |
| xy_byte | output | 8 | Status byte of the last accepted code |
| xy_valid | output | 1 | One-cycle pulse with a new status byte |
| trs_byte | output | 8 | Reference sequence byte |
| trs_valid | output | 1 | Sequence byte valid |
| gp_pin | output | 1 | General-purpose output |
| active_task | output | IDX_W | Index of current task |
| task_toggle | output | N_TASKS | Activation-parity flag per task |

## Verification
The bench builds the block with its defaults: two tasks and a one-bit task index. This covers the full contest between task A and task B, including both pulsing together, and the same-cycle clash of a software reset with an activation. All eight combinations of field, blanking and start/end are driven through the code path. A second strobe is placed inside a running sequence to cover that case.

// File: rtl/vtc_pkg.sv
package vtc_pkg;
    localparam logic [7:0] SYNC_ONES  = 8'hFF;
    localparam logic [7:0] SYNC_ZEROS = 8'h00;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_Z1   = 2'd1,
        PH_Z2   = 2'd2,
        PH_XY   = 2'd3
    } phase_e;
endpackage

// File: rtl/vtc_task_arbiter.sv
module vtc_task_arbiter #(
    parameter int N_TASKS = 2,
    parameter int IDX_W   = (N_TASKS > 1) ? $clog2(N_TASKS) : 1
) (
    input  logic [N_TASKS-1:0] req,
    input  logic               block,
    output logic               win_valid,
    output logic [IDX_W-1:0]   win_idx,
    output logic [N_TASKS-1:0] win_vec
);
    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        win_vec   = '0;
        // later (higher) indices overwrite earlier ones: highest wins
        for (int i = 0; i < N_TASKS; i++) begin
            if (req[i] && !block) begin
                win_valid = 1'b1;
                win_idx   = IDX_W'(i);
            end
        end
        if (win_valid) begin
            win_vec[win_idx] = 1'b1;
        end
    end
endmodule

// File: rtl/vtc_toggle_bank.sv
module vtc_toggle_bank #(
    parameter int N_TASKS = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic [N_TASKS-1:0] flip,
    output logic [N_TASKS-1:0] tog_q
);
    logic [N_TASKS-1:0] tog_d;

    for (genvar g = 0; g < N_TASKS; g++) begin : g_tog
        always_comb begin
            if (clr) begin
                tog_d[g] = 1'b0;
            end else if (flip[g]) begin
                tog_d[g] = ~tog_q[g];
            end else begin
                tog_d[g] = tog_q[g];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tog_q[g] <= 1'b0;
            end else begin
                tog_q[g] <= tog_d[g];
            end
        end
    end
endmodule

// File: rtl/vtc_xy_encode.sv
module vtc_xy_encode (
    input  logic       f_bit,
    input  logic       v_bit,
    input  logic       h_bit,
    input  logic       mark_inv,
    output logic [7:0] xy
);
    always_comb begin
        xy[7] = ~mark_inv;
        xy[6] = f_bit;
        xy[5] = v_bit;
        xy[4] = h_bit;
        xy[3] = v_bit ^ h_bit;
        xy[2] = f_bit ^ h_bit;
        xy[1] = f_bit ^ v_bit;
        xy[0] = f_bit ^ v_bit ^ h_bit;
    end
endmodule

// File: rtl/vid_timing_code_gen.sv
module vid_timing_code_gen #(
    parameter int N_TASKS = 2,
    parameter int IDX_W   = (N_TASKS > 1) ? $clog2(N_TASKS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               soft_rst,
    input  logic [N_TASKS-1:0] task_act,
    input  logic [N_TASKS-1:0] cfg_fid_sel,
    input  logic [N_TASKS-1:0] cfg_mark_inv,
    input  logic               field_id_in,
    input  logic               vblank_in,
    input  logic               code_is_eav,
    input  logic               code_req,
    input  logic               pin_sel,
    output logic [7:0]         xy_byte,
    output logic               xy_valid,
    output logic [7:0]         trs_byte,
    output logic               trs_valid,
    output logic               gp_pin,
    output logic [IDX_W-1:0]   active_task,
    output logic [N_TASKS-1:0] task_toggle
);
    import vtc_pkg::*;

    typedef struct packed {
        logic [IDX_W-1:0] active;
        logic             fid_sel;
        logic             mark_inv;
        phase_e           phase;
        logic [7:0]       xy;
        logic             xy_valid;
        logic [7:0]       trs;
        logic             trs_valid;
        logic             gp;
    } state_t;

    state_t s_d, s_q;

    logic               win_valid;
    logic [IDX_W-1:0]   win_idx;
    logic [N_TASKS-1:0] win_vec;
    logic [N_TASKS-1:0] tog_q;
    logic               cur_tog;
    logic               f_bit;
    logic [7:0]         xy_w;
    logic               accept;

    vtc_task_arbiter #(.N_TASKS(N_TASKS), .IDX_W(IDX_W)) u_arb (
        .req       (task_act),
        .block     (soft_rst),
        .win_valid (win_valid),
        .win_idx   (win_idx),
        .win_vec   (win_vec)
    );

    vtc_toggle_bank #(.N_TASKS(N_TASKS)) u_tog (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (soft_rst),
        .flip  (win_vec),
        .tog_q (tog_q)
    );

    always_comb begin
        cur_tog = tog_q[s_q.active];
        f_bit   = s_q.fid_sel ? cur_tog : field_id_in;
    end

    vtc_xy_encode u_enc (
        .f_bit    (f_bit),
        .v_bit    (vblank_in),
        .h_bit    (code_is_eav),
        .mark_inv (s_q.mark_inv),
        .xy       (xy_w)
    );

    always_comb begin
        s_d    = s_q;
        accept = code_req && (s_q.phase == PH_IDLE);

        // task selection and configuration capture
        if (soft_rst) begin
            s_d.active   = '0;
            s_d.fid_sel  = 1'b0;
            s_d.mark_inv = 1'b0;
        end else if (win_valid) begin
            s_d.active   = win_idx;
            s_d.fid_sel  = cfg_fid_sel[win_idx];
            s_d.mark_inv = cfg_mark_inv[win_idx];
        end

        // reference sequence
        s_d.xy_valid  = accept;
        s_d.trs_valid = 1'b0;
        s_d.trs       = '0;
        unique case (s_q.phase)
            PH_IDLE: begin
                if (accept) begin
                    s_d.xy        = xy_w;
                    s_d.trs       = SYNC_ONES;
                    s_d.trs_valid = 1'b1;
                    s_d.phase     = PH_Z1;
                end
            end
            PH_Z1: begin
                s_d.trs       = SYNC_ZEROS;
                s_d.trs_valid = 1'b1;
                s_d.phase     = PH_Z2;
            end
            PH_Z2: begin
                s_d.trs       = SYNC_ZEROS;
                s_d.trs_valid = 1'b1;
                s_d.phase     = PH_XY;
            end
            PH_XY: begin
                s_d.trs       = s_q.xy;
                s_d.trs_valid = 1'b1;
                s_d.phase     = PH_IDLE;
            end
            default: s_d.phase = PH_IDLE;
        endcase

        s_d.gp = pin_sel ? xy_w[7] : xy_w[6];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{active: '0, fid_sel: 1'b0, mark_inv: 1'b0, phase: PH_IDLE,
                     xy: '0, xy_valid: 1'b0, trs: '0, trs_valid: 1'b0, gp: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign xy_byte     = s_q.xy;
    assign xy_valid    = s_q.xy_valid;
    assign trs_byte    = s_q.trs;
    assign trs_valid   = s_q.trs_valid;
    assign gp_pin      = s_q.gp;
    assign active_task = s_q.active;
    assign task_toggle = tog_q;
endmodule

// File: rtl/vtc_checker.sv
module vtc_checker #(
    parameter int N_TASKS = 2,
    parameter int IDX_W   = (N_TASKS > 1) ? $clog2(N_TASKS) : 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               soft_rst,
    input logic [N_TASKS-1:0] task_act,
    input logic [7:0]         xy_byte,
    input logic               xy_valid,
    input logic [7:0]         trs_byte,
    input logic               trs_valid,
    input logic [IDX_W-1:0]   active_task,
    input logic [N_TASKS-1:0] task_toggle
);
    AST_HOLD_NO_ACT: assert property (@(posedge clk) disable iff (!rst_n)
        (!soft_rst && task_act == '0) |=> $stable(task_toggle)); // R1

    AST_LOW_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!soft_rst && task_act == N_TASKS'(1)) |=> (task_toggle[0] != $past(task_toggle[0]))); // R1

    AST_TOP_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
        (!soft_rst && task_act[N_TASKS-1]) |=> (active_task == IDX_W'(N_TASKS-1))); // R2

    AST_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
        xy_valid |-> (xy_byte[3:0] == {xy_byte[5]^xy_byte[4], xy_byte[6]^xy_byte[4],
                                       xy_byte[6]^xy_byte[5], ^xy_byte[6:4]})); // R5

    AST_SEQ_START: assert property (@(posedge clk) disable iff (!rst_n)
        xy_valid |-> (trs_valid && trs_byte == 8'hFF)); // R7

    AST_NO_REACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        xy_valid |=> !xy_valid); // R8

    AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (task_toggle == '0 && active_task == '0)); // R10
endmodule

bind vid_timing_code_gen vtc_checker #(.N_TASKS(N_TASKS), .IDX_W(IDX_W)) u_vtc_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .soft_rst    (soft_rst),
    .task_act    (task_act),
    .xy_byte     (xy_byte),
    .xy_valid    (xy_valid),
    .trs_byte    (trs_byte),
    .trs_valid   (trs_valid),
    .active_task (active_task),
    .task_toggle (task_toggle)
);

// File: tb/vid_timing_code_gen_bench.sv
`timescale 1ns/1ps
module vid_timing_code_gen_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       soft_rst = 1'b0;
    logic [1:0] task_act = '0;
    logic [1:0] cfg_fid_sel = '0;
    logic [1:0] cfg_mark_inv = '0;
    logic       field_id_in = 1'b0;
    logic       vblank_in = 1'b0;
    logic       code_is_eav = 1'b0;
    logic       code_req = 1'b0;
    logic       pin_sel = 1'b0;
    logic [7:0] xy_byte, trs_byte;
    logic       xy_valid, trs_valid, gp_pin;
    logic [0:0] active_task;
    logic [1:0] task_toggle;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // model state
    logic [1:0] m_tog = '0;
    logic       m_act = 1'b0;
    logic       m_fsel = 1'b0;
    logic       m_mark = 1'b0;

    always #2.5 clk = ~clk;

    vid_timing_code_gen u_vid_timing_code_gen (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .task_act(task_act),
        .cfg_fid_sel(cfg_fid_sel), .cfg_mark_inv(cfg_mark_inv),
        .field_id_in(field_id_in), .vblank_in(vblank_in), .code_is_eav(code_is_eav),
        .code_req(code_req), .pin_sel(pin_sel), .xy_byte(xy_byte), .xy_valid(xy_valid),
        .trs_byte(trs_byte), .trs_valid(trs_valid), .gp_pin(gp_pin),
        .active_task(active_task), .task_toggle(task_toggle)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_xy(input logic m, input logic f, input logic v, input logic h);
        return {~m, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    endfunction

    function automatic logic f_val(input logic fld);
        return m_fsel ? m_tog[m_act] : fld;
    endfunction

    task automatic activate(input logic [1:0] a);
        @(negedge clk);
        task_act = a;
        @(negedge clk);
        task_act = '0;
        if (a != 2'b00) begin
            m_act  = a[1] ? 1'b1 : 1'b0;
            m_tog[m_act] = ~m_tog[m_act];
            m_fsel = cfg_fid_sel[m_act];
            m_mark = cfg_mark_inv[m_act];
        end
    endtask

    task automatic code_seq(input string req, input logic f, input logic v, input logic h);
        logic [7:0] e;
        @(negedge clk);
        field_id_in = f; vblank_in = v; code_is_eav = h; code_req = 1'b1;
        e = exp_xy(m_mark, f_val(f), v, h);
        @(negedge clk);
        code_req = 1'b0;
        chk({req, " R7 xy_valid"}, 32'(xy_valid), 1);
        chk({req, " xy_byte"}, 32'(xy_byte), 32'(e));
        chk({req, " R7 byte0"}, {23'd0, trs_valid, trs_byte}, {23'd0, 1'b1, 8'hFF});
        @(negedge clk);
        chk({req, " R7 byte1"}, {23'd0, trs_valid, trs_byte}, {23'd0, 1'b1, 8'h00});
        @(negedge clk);
        chk({req, " R7 byte2"}, {23'd0, trs_valid, trs_byte}, {23'd0, 1'b1, 8'h00});
        @(negedge clk);
        chk({req, " R7 byte3"}, {23'd0, trs_valid, trs_byte}, {23'd0, 1'b1, e});
        @(negedge clk);
        chk({req, " R7 idle"}, {23'd0, trs_valid, trs_byte}, 32'd0);
    endtask

    task automatic t_reset();
        chk("R11 toggle", 32'(task_toggle), 0);
        chk("R11 active", 32'(active_task), 0);
        chk("R11 xy", {23'd0, xy_valid, xy_byte}, 0);
        chk("R11 trs", {23'd0, trs_valid, trs_byte}, 0);
        chk("R11 gp", 32'(gp_pin), 0);
    endtask

    task automatic t_codes();
        for (int k = 0; k < 8; k++) begin
            code_seq("R5 R3 R4 combo", k[2], k[1], k[0]);
        end
    endtask

    task automatic t_toggle();
        for (int k = 0; k < 3; k++) begin
            field_id_in = ~field_id_in;
            activate(2'b01);
            chk("R1 toggle A", 32'(task_toggle), 32'(m_tog));
        end
        activate(2'b10);
        chk("R1 toggle B, A held", 32'(task_toggle), 32'(m_tog));
        repeat (3) begin
            @(negedge clk);
            field_id_in = ~field_id_in;
        end
        @(negedge clk);
        chk("R1 field id no effect", 32'(task_toggle), 32'(m_tog));
    endtask

    task automatic t_prio();
        activate(2'b11);
        chk("R2 toggles", 32'(task_toggle), 32'(m_tog));
        chk("R2 active B", 32'(active_task), 1);
    endtask

    task automatic t_fid_mark();
        cfg_fid_sel = 2'b10; cfg_mark_inv = 2'b10;
        activate(2'b10);
        code_seq("R3 R4 toggle on bit6 mark", 1'b0, 1'b0, 1'b0);
        code_seq("R3 toggle ignores field", 1'b1, 1'b1, 1'b1);
        cfg_fid_sel = 2'b00; cfg_mark_inv = 2'b00;
        code_seq("R6 cfg change ignored", 1'b0, 1'b0, 1'b1);
        cfg_mark_inv = 2'b01;
        activate(2'b01);
        code_seq("R6 cfg captured at A", 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_busy();
        logic [7:0] e;
        @(negedge clk);
        field_id_in = 1'b0; vblank_in = 1'b1; code_is_eav = 1'b0; code_req = 1'b1;
        e = exp_xy(m_mark, f_val(1'b0), 1'b1, 1'b0);
        @(negedge clk);
        code_is_eav = 1'b1; vblank_in = 1'b0;
        @(negedge clk);
        chk("R8 no second pulse", 32'(xy_valid), 0);
        chk("R8 byte1", {23'd0, trs_valid, trs_byte}, {23'd0, 1'b1, 8'h00});
        @(negedge clk);
        code_req = 1'b0;
        chk("R8 byte2", {23'd0, trs_valid, trs_byte}, {23'd0, 1'b1, 8'h00});
        @(negedge clk);
        chk("R8 byte3 first code", {23'd0, trs_valid, trs_byte}, {23'd0, 1'b1, e});
        chk("R8 xy held", 32'(xy_byte), 32'(e));
        @(negedge clk);
    endtask

    task automatic t_gp();
        cfg_fid_sel = 2'b00; cfg_mark_inv = 2'b10;
        activate(2'b10);
        @(negedge clk);
        pin_sel = 1'b0; field_id_in = 1'b1;
        @(negedge clk);
        chk("R9 pin field", 32'(gp_pin), 1);
        field_id_in = 1'b0;
        @(negedge clk);
        chk("R9 pin field low", 32'(gp_pin), 0);
        pin_sel = 1'b1;
        @(negedge clk);
        chk("R9 pin task marker", 32'(gp_pin), 0);
        cfg_mark_inv = 2'b00;
        activate(2'b01);
        @(negedge clk);
        chk("R9 pin marker A", 32'(gp_pin), 1);
        pin_sel = 1'b0;
    endtask

    task automatic t_soft();
        cfg_fid_sel = 2'b11; cfg_mark_inv = 2'b11;
        activate(2'b10);
        @(negedge clk);
        soft_rst = 1'b1; task_act = 2'b01;
        @(negedge clk);
        soft_rst = 1'b0; task_act = 2'b00;
        m_tog = '0; m_act = 1'b0; m_fsel = 1'b0; m_mark = 1'b0;
        chk("R10 toggles clear", 32'(task_toggle), 0);
        chk("R10 active A", 32'(active_task), 0);
        code_seq("R10 defaults", 1'b1, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_codes();
        t_toggle();
        t_prio();
        t_fid_mark();
        t_busy();
        t_gp();
        t_soft();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule